// File: doc/BRIEF.md
# Mode-Selectable Burst Address Sequencer

This block generates the address for a burst of up to four accesses to a synchronous memory from one start address. A cycle with the load strobe `load_n` low and the select `sel_i` high captures the full start address, the access type (`wr_i`) and the first beat's byte-lane enables. Each following cycle with `load_n` high moves the burst to the next beat. Only the two low address bits change during a burst. The upper bits stay as loaded.

A static order input picks how the two low bits move. Linear order adds the beat number to the start value modulo 4. Interleaved order XORs the start value with the beat number. While the burst advances, the select and write-type inputs are ignored. The byte-lane enables, however, are sampled on every beat, so that each beat of a burst write can mask its own lanes. After the fourth beat, a further advance wraps back to the start value and does not carry into the upper bits.

Top module: `burst_addr_seq`

## Requirements
- R1: A clock edge with `load_n`=0 and `sel_i`=1 sets, in the following cycle, `addr_o` to the sampled `addr_i`, `beat_o` to 0, `active_o` to 1 and `wr_o` to the sampled `wr_i`.
- R2: A clock edge with `load_n`=0 and `sel_i`=0 ends any burst. In the following cycle `active_o`=0, `wr_o`=0 and `lane_we_o`=0, and `addr_o` and `beat_o` keep their previous values.
- R3: With `order_sel_i`=0 (linear), `addr_o[1:0]` equals (start[1:0] + `beat_o`) mod 4. For a start of 01 this gives 01, 10, 11, 00.
- R4: With `order_sel_i`=1 (interleaved), `addr_o[1:0]` equals start[1:0] XOR `beat_o`. For a start of 01 this gives 01, 00, 11, 10.
- R5: `addr_o[ADDR_W-1:2]` stays at the loaded value for every beat of a burst.
- R6: Each clock edge with `load_n`=1 during an active burst raises `beat_o` by one modulo 4. After beat 3 the next advance returns to beat 0, which is the start address.
- R7: `lane_we_o` is `lane_en_i` as sampled at the edge that starts each beat, when the burst is a write. It is 0 for a read burst and when idle.
- R8: During an advance, `sel_i` and `wr_i` have no effect. `active_o` stays 1 and `wr_o` keeps its loaded value.
- R9: After reset, `active_o`=0, `wr_o`=0, `beat_o`=0, `lane_we_o`=0 and `addr_o`=0.
- R10: A clock edge with `load_n`=1 while idle changes nothing. `active_o` stays 0 and `beat_o` and `addr_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Low: start a new burst (or deselect); high: advance |
| sel_i | input | 1 | Combined chip select, sampled only on a load |
| wr_i | input | 1 | Access type for the burst (1 = write), sampled only on a load |
| addr_i | input | ADDR_W | Start address |
| lane_en_i | input | LANES | Byte-lane write enables, sampled on every beat |
| order_sel_i | input | 1 | Static order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | 2 | Beat number within the burst |
| active_o | output | 1 | A burst is in progress |
| wr_o | output | 1 | The current burst is a write |
| lane_we_o | output | LANES | Byte-lane write enables for the current beat |

## Verification
All results are registered and are due one cycle after the edge that samples the stimulus: `addr_o`, `beat_o`, `active_o`, `wr_o` and `lane_we_o` describe the beat that edge started. The driver applies inputs at the falling edge and, at the same time, queues the values the following rising edge must produce. The monitor pops one entry per rising edge and compares it 2 ns later, while the outputs are settled and the inputs are still steady. The bench model computes linear order with an addition and interleaved order with an XOR. It covers every start value in both orders and runs each burst past the wrap point.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Ordering of the low address bits within one burst.
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Number of address bits that move within a burst (four beats).
  localparam int unsigned BURST_BITS = 2;
endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_n,
  input  logic                  sel_i,
  input  logic                  wr_i,
  output logic                  take_evt,
  output logic                  adv_evt,
  output logic                  next_wr_act,
  output logic                  active_q,
  output logic                  wr_q,
  output logic [BURST_BITS-1:0] beat_q
);
  logic load_evt;

  assign load_evt    = !load_n;
  assign take_evt    = load_evt && sel_i;
  // Select and write type are only looked at on a load.
  assign adv_evt     = load_n && active_q;
  assign next_wr_act = load_evt ? (sel_i && wr_i) : (active_q && wr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      beat_q   <= '0;
    end else if (load_evt) begin
      active_q <= sel_i;
      wr_q     <= sel_i && wr_i;
      if (sel_i) begin
        beat_q <= '0;
      end
    end else if (adv_evt) begin
      // Wraps modulo the burst length, back to the first beat.
      beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_evt,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (take_evt) begin
      base_q <= addr_i;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [BURST_BITS-1:0] beat_i,
  input  logic                  order_sel_i,
  output logic [ADDR_W-1:0]     addr_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_BITS;

  function automatic logic [BURST_BITS-1:0] lin_pos(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat
  );
    return start + beat;
  endfunction

  function automatic logic [BURST_BITS-1:0] xor_pos(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat
  );
    return start ^ beat;
  endfunction

  logic [BURST_BITS-1:0] low_lin;
  logic [BURST_BITS-1:0] low_xor;
  logic [BURST_BITS-1:0] low_sel;
  order_e                ord;

  assign ord     = order_e'(order_sel_i);
  assign low_lin = lin_pos(base_i[BURST_BITS-1:0], beat_i);
  assign low_xor = xor_pos(base_i[BURST_BITS-1:0], beat_i);
  assign low_sel = (ord == ORD_XOR) ? low_xor : low_lin;
  // Upper bits never take a carry from the low bits.
  assign addr_o  = {base_i[ADDR_W-1 -: HI_W], low_sel};
endmodule

// File: rtl/burst_lane_sample.sv
module burst_lane_sample #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             next_wr_act,
  input  logic [LANES-1:0] lane_en_i,
  output logic [LANES-1:0] lane_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q[g] <= 1'b0;
      end else begin
        lane_q[g] <= next_wr_act && lane_en_i[g];
      end
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o,
  output logic              active_o,
  output logic              wr_o,
  output logic [LANES-1:0]  lane_we_o
);
  // Named internal events, visible to the bound checker.
  logic                  take_evt;
  logic                  adv_evt;
  logic                  next_wr_act;
  logic [BURST_BITS-1:0] beat_q;
  logic [ADDR_W-1:0]     base_q;

  burst_beat_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_n      (load_n),
    .sel_i       (sel_i),
    .wr_i        (wr_i),
    .take_evt    (take_evt),
    .adv_evt     (adv_evt),
    .next_wr_act (next_wr_act),
    .active_q    (active_o),
    .wr_q        (wr_o),
    .beat_q      (beat_q)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) base_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_evt (take_evt),
    .addr_i   (addr_i),
    .base_q   (base_q)
  );

  burst_order_map #(.ADDR_W(ADDR_W)) map_i (
    .base_i      (base_q),
    .beat_i      (beat_q),
    .order_sel_i (order_sel_i),
    .addr_o      (addr_o)
  );

  burst_lane_sample #(.LANES(LANES)) lane_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .next_wr_act (next_wr_act),
    .lane_en_i   (lane_en_i),
    .lane_q      (lane_we_o)
  );

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_n,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [LANES-1:0]  lane_en_i,
  input logic              order_sel_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        beat_o,
  input logic              active_o,
  input logic              wr_o,
  input logic [LANES-1:0]  lane_we_o,
  input logic              adv_evt
);
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && sel_i) |=> (addr_o == $past(addr_i)) && (beat_o == 2'd0) && active_o && (wr_o == $past(wr_i))); // R1

  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !sel_i) |=> !active_o && !wr_o && (lane_we_o == '0)); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !order_sel_i) |=> order_sel_i || (addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1))); // R3

  AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && order_sel_i) |=> !order_sel_i || ((addr_o[1:0] ^ $past(addr_o[1:0])) == (beat_o ^ $past(beat_o)))); // R4

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && load_n) |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])); // R5

  AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && load_n) |=> beat_o == 2'($past(beat_o) + 2'd1)); // R6

  AST_LANE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && sel_i && wr_i) |=> lane_we_o == $past(lane_en_i)); // R7

  AST_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we_o != '0) |-> (active_o && wr_o)); // R7

  AST_ADV_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && load_n) |=> active_o && (wr_o == $past(wr_o))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && load_n) |=> !active_o && $stable(beat_o) && $stable(addr_o[ADDR_W-1:2])); // R10
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_n      (load_n),
  .sel_i       (sel_i),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .lane_en_i   (lane_en_i),
  .order_sel_i (order_sel_i),
  .addr_o      (addr_o),
  .beat_o      (beat_o),
  .active_o    (active_o),
  .wr_o        (wr_o),
  .lane_we_o   (lane_we_o),
  .adv_evt     (adv_evt)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int unsigned AW = 20;
  localparam int unsigned LN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_n = 1'b1;
  logic          sel_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [LN-1:0] lane_en_i = '0;
  logic          order_sel_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;
  logic          active_o;
  logic          wr_o;
  logic [LN-1:0] lane_we_o;

  always #4 clk = ~clk; // 125 MHz

  burst_addr_seq #(.ADDR_W(AW), .LANES(LN)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .lane_en_i(lane_en_i), .order_sel_i(order_sel_i),
    .addr_o(addr_o), .beat_o(beat_o), .active_o(active_o), .wr_o(wr_o),
    .lane_we_o(lane_we_o)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    beat;
    logic          act;
    logic          wr;
    logic [LN-1:0] lanes;
    string         tag;
  } exp_t;

  exp_t  exp_q[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 0;

  // Bench model state
  logic          m_act = 0;
  logic          m_wr = 0;
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model_addr(input logic ord);
    logic [1:0] lo;
    if (ord) lo = m_start[1:0] ^ m_beat;
    else     lo = 2'((int'(m_start[1:0]) + int'(m_beat)) % 4);
    return {m_start[AW-1:2], lo};
  endfunction

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic step(input logic ld_n, input logic sel, input logic wr, input logic [AW-1:0] a,
                      input logic [LN-1:0] ln, input logic ord, input string tag);
    exp_t e;
    @(negedge clk);
    load_n = ld_n; sel_i = sel; wr_i = wr; addr_i = a; lane_en_i = ln; order_sel_i = ord;
    if (!ld_n) begin
      if (sel) begin
        m_start = a;
        m_beat  = '0;
      end
      m_act = sel;
      m_wr  = sel & wr;
    end else if (m_act) begin
      m_beat = m_beat + 2'd1;
    end
    e.addr  = model_addr(ord);
    e.beat  = m_beat;
    e.act   = m_act;
    e.wr    = m_wr;
    e.lanes = (m_act && m_wr) ? ln : '0;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "addr_low", 32'(addr_o[1:0]), 32'(e.addr[1:0]));
        chk(e.tag == "R3" || e.tag == "R4" ? "R5" : e.tag, "addr_high", 32'(addr_o[AW-1:2]), 32'(e.addr[AW-1:2]));
        chk(e.tag, "beat", 32'(beat_o), 32'(e.beat));
        chk(e.tag, "active", 32'(active_o), 32'(e.act));
        chk(e.tag, "wr", 32'(wr_o), 32'(e.wr));
        chk(e.tag == "R3" || e.tag == "R4" ? "R7" : e.tag, "lanes", 32'(lane_we_o), 32'(e.lanes));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset values
    chk("R9", "addr", 32'(addr_o), 0);
    chk("R9", "beat", 32'(beat_o), 0);
    chk("R9", "active", 32'(active_o), 0);
    chk("R9", "wr", 32'(wr_o), 0);
    chk("R9", "lanes", 32'(lane_we_o), 0);
    rst_n = 1'b1;

    // R10: advancing while idle
    step(1, 1, 1, 20'hABCDE, 4'hF, 0, "R10");

    // R1/R3/R6/R8/R7: linear write burst from low bits 01, sel/wr toggled on advance
    step(0, 1, 1, 20'h12345, 4'b0011, 0, "R1");
    step(1, 0, 0, 20'h0FFFF, 4'b1100, 0, "R8");
    step(1, 1, 0, 20'h00000, 4'b1010, 0, "R3");
    step(1, 0, 1, 20'h33333, 4'b0101, 0, "R3");
    step(1, 0, 0, 20'h44444, 4'b1111, 0, "R6");
    step(1, 0, 0, 20'h44444, 4'b0001, 0, "R6");

    // R4: interleaved read burst from 01
    step(0, 1, 0, 20'h54321, 4'hF, 1, "R1");
    for (int i = 0; i < 5; i++) step(1, 1, 1, 20'h0, 4'hF, 1, i == 4 ? "R6" : "R4");

    // R2: deselect mid burst, then R10 idle advance
    step(0, 1, 1, 20'h7FFFE, 4'h9, 1, "R1");
    step(1, 0, 0, 20'h0, 4'h6, 1, "R4");
    step(0, 0, 1, 20'h11111, 4'hF, 1, "R2");
    step(1, 1, 1, 20'h22222, 4'hF, 1, "R10");
    step(1, 1, 1, 20'h22222, 4'hF, 0, "R10");

    // Every start value in both orders, full burst plus wrap
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        step(0, 1, s[0], {18'(20'h2A5A5 >> s), 2'(s)}, 4'(s + 3), 1'(ord), "R1");
        for (int b = 0; b < 5; b++)
          step(1, 0, 0, 20'h0, 4'(b * 5), 1'(ord), ord == 1 ? "R4" : "R3");
      end
    end

    // Reload straight after reload (no advance between)
    step(0, 1, 1, 20'hFFFFF, 4'h8, 0, "R1");
    step(0, 1, 0, 20'h00002, 4'h8, 0, "R1");
    step(1, 0, 1, 20'h0, 4'h8, 0, "R7");

    step(1, 0, 0, 20'h0, 4'h0, 0, "R3");
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule